// File: doc/BRIEF.md
# Microprocessor Power and Pushbutton Supervisor

This block is the digital half of a microprocessor supervisor. Two analog comparators sit outside it and deliver clean flags. One says whether the supply is in tolerance. The other says whether a separate sense input is in tolerance. A third input is an active-low manual reset button. The block turns these inputs into an early power-fail interrupt and a processor reset. The reset is driven on two pins of opposite polarity.

Every input passes through a synchronizer first. The sense flag drives the interrupt directly after synchronization, with no stretching. The supply flag and the debounced button together form a single fault condition. That fault feeds one shared hold timer. The timer keeps reset active while the fault is present. It then holds reset for a further fixed number of clock cycles, so the supply and the processor have time to settle. Any new fault during the hold restarts the full count. The hold period and the debounce window are parameters counted in clock cycles. In silicon they correspond to about 130 ms and a few milliseconds.

Top module: `cpu_supervisor`

## Requirements
- R1: A low (out of tolerance) on `sense_ok_i` drives `irq_n_o` low on the second rising clock edge after the change.
- R2: When `sense_ok_i` returns high, `irq_n_o` goes high on the second rising edge after the change. No stretch or hold is applied.
- R3: While the synchronized supply flag is low, reset is asserted. Reset asserts on the third rising edge after `supply_ok_i` falls.
- R4: After `supply_ok_i` rises, reset stays asserted and releases on rising edge HOLD_CYCLES+2 after the change. It is never released earlier.
- R5: `button_n_i` counts as pressed only after it has been low for DEBOUNCE_CYCLES consecutive synchronized cycles. A shorter low pulse leaves the reset outputs unchanged.
- R6: A valid press asserts reset on rising edge DEBOUNCE_CYCLES+3 after the button falls. Reset stays asserted while the button is held.
- R7: `reset_n_o` is always the inverse of `reset_o`.
- R8: A supply fault or button press that arrives while the hold count is running restarts the full HOLD_CYCLES count.
- R9: While `rst_n` is low, `reset_o` is 1, `reset_n_o` is 0 and `irq_n_o` is 1. After `rst_n` releases with the supply in tolerance, reset releases on rising edge HOLD_CYCLES+2.
- R10: A button release is also debounced. A high bounce shorter than DEBOUNCE_CYCLES does not end the press. Reset then releases on rising edge DEBOUNCE_CYCLES+HOLD_CYCLES+2 after the final rising edge of `button_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| supply_ok_i | input | 1 | Supply comparator flag, 1 = in tolerance |
| sense_ok_i | input | 1 | Sense-input comparator flag, 1 = in tolerance |
| button_n_i | input | 1 | Manual reset button, active low, may bounce |
| irq_n_o | output | 1 | Early power-fail interrupt, active low |
| reset_n_o | output | 1 | Processor reset, active low |
| reset_o | output | 1 | Processor reset, active high |

## Verification
Each result has a fixed latency from the input edge that causes it. The interrupt follows the sense flag two edges later. Reset asserts three edges after a supply fault, and DEBOUNCE_CYCLES+3 edges after a press starts. Release comes HOLD_CYCLES+2 edges after the supply recovers, or DEBOUNCE_CYCLES+HOLD_CYCLES+2 edges after the button is finally released.

The bench drives inputs on falling edges and counts falling edges until each output changes, comparing that count with the exact latency. In parallel, a behavioural model steps once per rising edge and is compared with all three outputs on every falling edge. Bounces of DEBOUNCE_CYCLES-1 cycles, and faults injected in the middle of a hold, check the boundary and restart cases.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Synchronized view of the three raw supervisor inputs
    typedef struct packed {
        logic supply_ok;
        logic sense_ok;
        logic button_n;
    } sup_flags_t;

    localparam int SUP_FLAG_W = $bits(sup_flags_t);

    // Safe values while in reset: supply treated as failed, no warning, button released
    localparam sup_flags_t SUP_FLAGS_RST = '{supply_ok: 1'b0, sense_ok: 1'b1, button_n: 1'b1};

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sup_pkg::sup_flags_t raw_i,
    output sup_pkg::sup_flags_t sync_o
);
    import sup_pkg::*;

    sup_flags_t stage_d [STAGES];
    sup_flags_t stage_q [STAGES];

    always_comb begin
        stage_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= SUP_FLAGS_RST;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
    parameter int DEBOUNCE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic button_n_i,
    output logic pressed_o
);
    localparam int CW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYCLES - 1);

    typedef struct packed {
        logic          pressed;
        logic [CW-1:0] cnt;
    } db_state_t;

    db_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if ((!button_n_i) != st_q.pressed) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.pressed = !button_n_i;
                st_d.cnt     = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pressed: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pressed_o = st_q.pressed;

    // The debounced level only changes after a full window of disagreement (R5, R10)
    assert_full_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.pressed) |-> $past(st_q.cnt) == CNT_LAST);

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
    parameter int HOLD_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    output logic active_o
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fault_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == HOLD_LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    assert_fault_asserts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> active_o);

    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= HOLD_LAST);

    assert_release_after_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.active) |-> ($past(st_q.cnt) == HOLD_LAST && !$past(fault_i)));

    assert_restart_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> st_q.cnt == '0);

endmodule

// File: rtl/cpu_supervisor.sv
module cpu_supervisor #(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 500_000,
    parameter int HOLD_CYCLES     = 6_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic sense_ok_i,
    input  logic button_n_i,
    output logic irq_n_o,
    output logic reset_n_o,
    output logic reset_o
);
    import sup_pkg::*;

    sup_flags_t raw_flags;
    sup_flags_t sync_flags;
    logic       btn_pressed;
    logic       fault;
    logic       hold_active;

    assign raw_flags = '{supply_ok: supply_ok_i, sense_ok: sense_ok_i, button_n: button_n_i};

    sup_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_flags),
        .sync_o (sync_flags)
    );

    sup_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) debounce_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .button_n_i (sync_flags.button_n),
        .pressed_o  (btn_pressed)
    );

    assign fault = !sync_flags.supply_ok || btn_pressed;

    sup_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_i  (fault),
        .active_o (hold_active)
    );

    assign irq_n_o   = sync_flags.sense_ok;
    assign reset_o   = hold_active;
    assign reset_n_o = !hold_active;

    // A debounced press keeps reset asserted (R6)
    assert_press_holds_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        btn_pressed |=> reset_o);

endmodule

// File: tb/cpu_supervisor_tb_top.sv
module cpu_supervisor_tb_top;

    localparam int DEB  = 8;
    localparam int HOLD = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic sense_ok = 1'b1;
    logic button_n = 1'b1;
    logic irq_n, reset_n, reset_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    cpu_supervisor #(
        .SYNC_STAGES(2), .DEBOUNCE_CYCLES(DEB), .HOLD_CYCLES(HOLD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .supply_ok_i(supply_ok), .sense_ok_i(sense_ok), .button_n_i(button_n),
        .irq_n_o(irq_n), .reset_n_o(reset_n), .reset_o(reset_hi)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, stepped once per rising edge
    int sup_q[$], sen_q[$], btn_q[$];
    int m_sup, m_sen, m_btn;
    int m_pressed, m_dbcnt, m_act, m_cnt;

    task automatic model_reset();
        sup_q = {0}; sen_q = {1}; btn_q = {1};
        m_sup = 0; m_sen = 1; m_btn = 1;
        m_pressed = 0; m_dbcnt = 0; m_act = 1; m_cnt = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            if (m_sup == 0 || m_pressed == 1) begin
                m_act = 1; m_cnt = 0;
            end else if (m_act == 1) begin
                if (m_cnt == HOLD - 1) begin m_act = 0; m_cnt = 0; end
                else m_cnt++;
            end
            if ((m_btn == 0 ? 1 : 0) != m_pressed) begin
                if (m_dbcnt == DEB - 1) begin m_pressed = (m_btn == 0); m_dbcnt = 0; end
                else m_dbcnt++;
            end else begin
                m_dbcnt = 0;
            end
            sup_q.push_back(int'(supply_ok)); m_sup = sup_q.pop_front();
            sen_q.push_back(int'(sense_ok));  m_sen = sen_q.pop_front();
            btn_q.push_back(int'(button_n));  m_btn = btn_q.pop_front();
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check(int'(irq_n) == m_sen, "R1/R2 model irq_n", int'(irq_n), m_sen);
            check(int'(reset_hi) == m_act, "R3/R4/R8 model reset", int'(reset_hi), m_act);
            check(reset_n == !reset_hi, "R7 polarity", int'(reset_n), int'(!reset_hi));
        end
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count falling edges until reset_o takes the given value
    task automatic edges_until(input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (reset_hi !== val && n < 10 * (HOLD + DEB));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int n;
        bit seen;
        wait_neg(3);
        // R9: state during reset
        check(reset_hi == 1'b1, "R9 reset_o in reset", int'(reset_hi), 1);
        check(reset_n == 1'b0, "R9 reset_n_o in reset", int'(reset_n), 0);
        check(irq_n == 1'b1, "R9 irq_n_o in reset", int'(irq_n), 1);
        supply_ok = 1'b1;
        rst_n = 1'b1;
        edges_until(1'b0, n);
        check(n == HOLD + 2, "R9 release after reset", n, HOLD + 2);

        // R1 / R2: interrupt latency, no stretch
        wait_neg(4);
        sense_ok = 1'b0;
        wait_neg(1);
        check(irq_n == 1'b1, "R1 irq one edge", int'(irq_n), 1);
        wait_neg(1);
        check(irq_n == 1'b0, "R1 irq two edges", int'(irq_n), 0);
        check(reset_hi == 1'b0, "R1 sense does not reset", int'(reset_hi), 0);
        wait_neg(5);
        sense_ok = 1'b1;
        wait_neg(1);
        check(irq_n == 1'b0, "R2 irq one edge", int'(irq_n), 0);
        wait_neg(1);
        check(irq_n == 1'b1, "R2 irq two edges", int'(irq_n), 1);

        // R3 / R4: supply fault and recovery
        wait_neg(3);
        supply_ok = 1'b0;
        wait_neg(2);
        check(reset_hi == 1'b0, "R3 reset before third edge", int'(reset_hi), 0);
        wait_neg(1);
        check(reset_hi == 1'b1, "R3 reset at third edge", int'(reset_hi), 1);
        wait_neg(3 * HOLD);
        check(reset_hi == 1'b1, "R3 reset held during fault", int'(reset_hi), 1);
        supply_ok = 1'b1;
        edges_until(1'b0, n);
        check(n == HOLD + 2, "R4 hold length after supply", n, HOLD + 2);

        // R5: bounce shorter than the window is ignored
        wait_neg(4);
        button_n = 1'b0;
        wait_neg(DEB - 1);
        button_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 3 * DEB; i++) begin
            @(negedge clk);
            if (reset_hi) seen = 1'b1;
        end
        check(!seen, "R5 short press ignored", int'(seen), 0);

        // R6 / R10: valid press, release with a bounce
        button_n = 1'b0;
        edges_until(1'b1, n);
        check(n == DEB + 3, "R6 press to reset", n, DEB + 3);
        wait_neg(2 * HOLD);
        check(reset_hi == 1'b1, "R6 reset held while pressed", int'(reset_hi), 1);
        button_n = 1'b1;
        wait_neg(DEB - 1);
        button_n = 1'b0;
        wait_neg(5);
        check(reset_hi == 1'b1, "R10 release bounce ignored", int'(reset_hi), 1);
        button_n = 1'b1;
        edges_until(1'b0, n);
        check(n == DEB + HOLD + 2, "R10 release after final edge", n, DEB + HOLD + 2);

        // R8: fault during hold restarts the count
        wait_neg(4);
        supply_ok = 1'b0;
        wait_neg(3);
        supply_ok = 1'b1;
        wait_neg(HOLD / 2 + 2);
        check(reset_hi == 1'b1, "R8 still in hold", int'(reset_hi), 1);
        supply_ok = 1'b0;
        wait_neg(1);
        supply_ok = 1'b1;
        edges_until(1'b0, n);
        check(n == HOLD + 2, "R8 restart after supply glitch", n, HOLD + 2);

        // R8: button press during hold restarts the count
        wait_neg(4);
        supply_ok = 1'b0;
        wait_neg(3);
        supply_ok = 1'b1;
        wait_neg(HOLD / 2);
        button_n = 1'b0;
        wait_neg(DEB + 4);
        button_n = 1'b1;
        edges_until(1'b0, n);
        check(n == DEB + HOLD + 2, "R8 restart after press", n, DEB + HOLD + 2);

        // R9: reset asserted again mid-run
        wait_neg(4);
        rst_n = 1'b0;
        wait_neg(1);
        check(reset_hi == 1'b1, "R9 reset re-asserted", int'(reset_hi), 1);
        rst_n = 1'b1;
        edges_until(1'b0, n);
        check(n == HOLD + 2, "R9 release after second reset", n, HOLD + 2);

        wait_neg(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule